// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal sync, vertical sync, composite sync and blanking signals for a raster display. It runs in the pixel clock domain. Software-chosen timing values reach it as three static words: one each for the horizontal and the vertical axis, and one holding both total lengths. Each axis is described by a sync width, a gate delay, a visible gate length and a total length. Four polarity inputs let the board adapt each of the four display outputs to the monitor or panel attached.

Next to the display outputs, the block gives a per-pixel visible strobe for a pixel pipeline. It also gives two single-cycle event pulses: one at the last clock of every line and one at the first clock of every frame, where vertical sync begins. Designers can use these pulses for interrupts or frame-buffer bank switching. The timing words are copied into shadow registers only when the generator starts and when a frame wraps, so software can rewrite them at any time without tearing the picture.

Top module: `vid_timing_gen`

## Requirements
- R1: A line lasts h_total+1 clocks, with the pixel position counting 0 to h_total. `line_end_o` is high for exactly the clock at position h_total and low otherwise.
- R2: The raw horizontal sync is active at positions 0 to hs of every line, which is hs+1 clocks, where hs is `h_cfg[31:24]`.
- R3: The line counter advances only on the last clock of a line. A frame is v_total+1 lines long. The raw vertical sync is active for whole lines 0 to vs, where vs is `v_cfg[31:24]`.
- R4: On each axis the visible gate starts at position sync+gate_delay+2 and lasts gate+1 positions. Gate delay is bits [23:16] of the axis word and gate is bits [15:0]. `pix_vis_o` is high only where the horizontal and vertical gates overlap.
- R5: The raw blank is active on every clock where `pix_vis_o` is low, so pixel data counts as valid only while blank is inactive.
- R6: The raw composite sync is the exclusive-or of the raw horizontal and raw vertical syncs.
- R7: Each of `hsync_o`, `vsync_o`, `csync_o` and `blank_o` equals its raw signal XOR its own polarity input. A polarity input of 1 makes that output active low.
- R8: `len_cfg[31:16]` is h_total and `len_cfg[15:0]` is v_total. All three words are sampled when the generator starts and on the clock where the frame wraps. A change at any other time does not affect the frame in progress.
- R9: `vsync_start_o` is high for exactly the first clock of every frame, at position (0,0).
- R10: While `rst` or a low `en` is sampled, the next clock leaves both counters at zero. The syncs are then inactive, blank is active and every strobe is low. One clock after both are released, the output shows position (0,0).
- R11: When the gate reaches past the total length, no position beyond h_total (or v_total) is ever visible. The window is cut at the end of the line or frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the generator idle |
| h_cfg | input | 2*SW+LW | Horizontal word {sync, gate delay, gate} |
| v_cfg | input | 2*SW+LW | Vertical word {sync, gate delay, gate} |
| len_cfg | input | 2*LW | Totals {h_total, v_total} |
| pol_h | input | 1 | Horizontal sync polarity invert |
| pol_v | input | 1 | Vertical sync polarity invert |
| pol_c | input | 1 | Composite sync polarity invert |
| pol_b | input | 1 | Blank polarity invert |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blanking |
| pix_vis_o | output | 1 | Visible-pixel strobe, active high |
| line_end_o | output | 1 | Last clock of a line |
| vsync_start_o | output | 1 | First clock of a frame |

## Verification
The bench builds the block with its default field widths: 8-bit sync and delay fields and 16-bit gates and totals. The packed field positions are therefore exercised exactly as specified. The programmed totals are kept small, so one run crosses hundreds of line and frame wraps. This brings within reach the corner cases of zero-width sync and delay, a one-pixel gate, a gate cut off by the total, and a configuration rewritten in the middle of a frame.

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int SW = 8,
  parameter int LW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [2*SW+LW-1:0]   h_cfg,
  input  logic [2*SW+LW-1:0]   v_cfg,
  input  logic [2*LW-1:0]      len_cfg,
  input  logic                 pol_h,
  input  logic                 pol_v,
  input  logic                 pol_c,
  input  logic                 pol_b,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 csync_o,
  output logic                 blank_o,
  output logic                 pix_vis_o,
  output logic                 line_end_o,
  output logic                 vsync_start_o
);
  localparam int WW = 2*SW + LW;
  localparam int CW = LW + 1;

  function automatic logic in_sync(input logic [LW-1:0] c, input logic [WW-1:0] w);
    return CW'(c) <= CW'(w[WW-1 -: SW]);
  endfunction

  function automatic logic in_gate(input logic [LW-1:0] c, input logic [WW-1:0] w);
    logic [CW-1:0] g0, g1;
    g0 = CW'(w[WW-1 -: SW]) + CW'(w[WW-SW-1 -: SW]) + CW'(2);
    g1 = g0 + CW'(w[LW-1:0]);
    return (CW'(c) >= g0) && (CW'(c) <= g1);
  endfunction

  logic          run;
  logic [LW-1:0] hcnt, vcnt;
  logic [WW-1:0] hsh, vsh;
  logic [2*LW-1:0] lsh;
  logic          h_last, v_last;
  logic          hs_r, vs_r, vis;

  assign h_last = (hcnt == lsh[2*LW-1:LW]);
  assign v_last = (vcnt == lsh[LW-1:0]);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run  <= 1'b0;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      run <= 1'b1;
      if (run) begin
        if (h_last) begin
          hcnt <= '0;
          vcnt <= v_last ? '0 : vcnt + 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
    if (rst || !en || !run || (h_last && v_last)) begin
      hsh <= h_cfg;
      vsh <= v_cfg;
      lsh <= len_cfg;
    end
  end

  assign hs_r = run && in_sync(hcnt, hsh);
  assign vs_r = run && in_sync(vcnt, vsh);
  assign vis  = run && in_gate(hcnt, hsh) && in_gate(vcnt, vsh);

  assign hsync_o       = hs_r ^ pol_h;
  assign vsync_o       = vs_r ^ pol_v;
  assign csync_o       = (hs_r ^ vs_r) ^ pol_c;
  assign blank_o       = ~vis ^ pol_b;
  assign pix_vis_o     = vis;
  assign line_end_o    = run && h_last;
  assign vsync_start_o = run && (hcnt == '0) && (vcnt == '0);
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk #(
  parameter int SW = 8,
  parameter int LW = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               run,
  input logic [LW-1:0]      hcnt,
  input logic [LW-1:0]      vcnt,
  input logic [2*SW+LW-1:0] hsh,
  input logic [2*SW+LW-1:0] vsh,
  input logic [2*LW-1:0]    lsh,
  input logic               h_last,
  input logic               v_last,
  input logic               hsync_o,
  input logic               vsync_o,
  input logic               blank_o,
  input logic               pix_vis_o,
  input logic               line_end_o,
  input logic               vsync_start_o,
  input logic               pol_h,
  input logic               pol_v,
  input logic               pol_b
);
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    line_end_o |=> (hcnt == '0));

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (run && en && !h_last) |=> (hcnt == $past(hcnt) + 1'b1));

  a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
    (run && en && !h_last) |=> $stable(vcnt));

  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (run && en && !(h_last && v_last)) |=> ($stable(hsh) && $stable(vsh) && $stable(lsh)));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pix_vis_o && !line_end_o && !vsync_start_o && (blank_o == !pol_b)));

  a_r9_frame_start_syncs: assert property (@(posedge clk) disable iff (rst)
    vsync_start_o |-> ((hsync_o != pol_h) && (vsync_o != pol_v)));
endmodule

bind vid_timing_gen vid_timing_gen_chk #(.SW(SW), .LW(LW)) u_chk (.*);

// File: tb/sim_vid_timing_gen.sv
module sim_vid_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, en, pol_h, pol_v, pol_c, pol_b;
  logic [31:0] h_cfg, v_cfg, len_cfg;
  logic hsync_o, vsync_o, csync_o, blank_o, pix_vis_o, line_end_o, vsync_start_o;

  int nchk = 0, nfail = 0, ncyc = 0;
  int mhs, mhd, mhg, mht, mvs, mvd, mvg, mvt;
  int x = 0, y = 0;
  bit m_run = 0;
  string htag = "R2", vtag = "R4", ltag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_timing_gen u0 (.*);

  function automatic bit f_sync(int c, int s);
    return c <= s;
  endfunction

  function automatic bit f_gate(int c, int s, int d, int g);
    return (c >= s + d + 2) && (c <= s + d + 2 + g);
  endfunction

  task automatic chk(bit ok, string tag, string nm, int a, int e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d (x=%0d y=%0d t=%0t)", tag, nm, a, e, x, y, $time);
    end
  endtask

  task automatic load_model();
    mhs = int'(h_cfg[31:24]); mhd = int'(h_cfg[23:16]); mhg = int'(h_cfg[15:0]);
    mvs = int'(v_cfg[31:24]); mvd = int'(v_cfg[23:16]); mvg = int'(v_cfg[15:0]);
    mht = int'(len_cfg[31:16]); mvt = int'(len_cfg[15:0]);
  endtask

  task automatic adv();
    if (rst || !en) m_run = 0;
    else if (!m_run) begin m_run = 1; x = 0; y = 0; load_model(); end
    else if (x == mht) begin
      x = 0;
      if (y == mvt) begin y = 0; load_model(); end
      else y++;
    end else x++;
  endtask

  task automatic compare();
    bit hr, vr, vis;
    if (!m_run) begin
      chk(hsync_o == pol_h, "R10", "hsync idle", int'(hsync_o), int'(pol_h));
      chk(vsync_o == pol_v, "R10", "vsync idle", int'(vsync_o), int'(pol_v));
      chk(csync_o == pol_c, "R10", "csync idle", int'(csync_o), int'(pol_c));
      chk(blank_o == !pol_b, "R10", "blank idle", int'(blank_o), int'(!pol_b));
      chk(!pix_vis_o && !line_end_o && !vsync_start_o, "R10", "strobes idle",
          int'({pix_vis_o, line_end_o, vsync_start_o}), 0);
    end else begin
      hr  = f_sync(x, mhs);
      vr  = f_sync(y, mvs);
      vis = f_gate(x, mhs, mhd, mhg) && f_gate(y, mvs, mvd, mvg);
      chk(hsync_o == (hr ^ pol_h), htag, "hsync", int'(hsync_o), int'(hr ^ pol_h));
      chk(vsync_o == (vr ^ pol_v), "R3", "vsync", int'(vsync_o), int'(vr ^ pol_v));
      chk(csync_o == (hr ^ vr ^ pol_c), "R6", "csync", int'(csync_o), int'(hr ^ vr ^ pol_c));
      chk(blank_o == (!vis ^ pol_b), "R5", "blank", int'(blank_o), int'(!vis ^ pol_b));
      chk(pix_vis_o == vis, vtag, "visible", int'(pix_vis_o), int'(vis));
      chk(line_end_o == (x == mht), ltag, "line_end", int'(line_end_o), int'(x == mht));
      chk(vsync_start_o == (x == 0 && y == 0), "R9", "vsync_start",
          int'(vsync_start_o), int'(x == 0 && y == 0));
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      adv();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic set_cfg(int hs, int hd, int hg, int ht, int vs, int vd, int vg, int vt);
    h_cfg   = {hs[7:0], hd[7:0], hg[15:0]};
    v_cfg   = {vs[7:0], vd[7:0], vg[15:0]};
    len_cfg = {ht[15:0], vt[15:0]};
  endtask

  task automatic rand_cfg();
    set_cfg(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
            int'($urandom_range(0, 30)), int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
            int'($urandom_range(0, 8)), int'($urandom_range(0, 15)));
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired after %0d cycles", ncyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; en = 1; pol_h = 0; pol_v = 0; pol_c = 0; pol_b = 0;
    set_cfg(1, 0, 5, 12, 0, 1, 3, 7);
    cyc(3);
    rst = 0;
    cyc(220);

    rst = 1; set_cfg(0, 0, 0, 3, 0, 0, 0, 2); cyc(2);
    rst = 0; cyc(40);

    htag = "R7";
    pol_h = 1; pol_v = 1; pol_c = 1; pol_b = 1;
    rst = 1; set_cfg(2, 1, 4, 14, 1, 0, 2, 6); cyc(2);
    rst = 0; cyc(150);
    pol_h = 0; pol_v = 0; pol_c = 0; pol_b = 0;
    htag = "R2";

    vtag = "R11";
    rst = 1; set_cfg(1, 1, 40, 10, 0, 0, 30, 5); cyc(2);
    rst = 0; cyc(200);
    vtag = "R4";

    ltag = "R8";
    rst = 1; set_cfg(1, 0, 5, 12, 0, 1, 3, 7); cyc(2);
    rst = 0; cyc(20);
    set_cfg(3, 2, 9, 20, 1, 1, 4, 9);
    cyc(400);
    ltag = "R1";

    en = 0; cyc(5);
    en = 1; cyc(60);
    rst = 1; cyc(2);
    rst = 0; cyc(60);

    for (int k = 0; k < 40; k++) begin
      rand_cfg();
      pol_h = 1'($urandom_range(0, 1)); pol_v = 1'($urandom_range(0, 1));
      pol_c = 1'($urandom_range(0, 1)); pol_b = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 4) == 0) begin en = 0; cyc(int'($urandom_range(1, 4))); en = 1; end
      cyc(int'($urandom_range(50, 700)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule